// File: doc/BRIEF.md
# 64-Point Radix-2 FFT Sequencer

This block computes a 64-point forward discrete Fourier transform on complex samples with 8-bit real and 8-bit imaginary parts. It uses the decimation-in-time radix-2 method with one butterfly unit that is shared by all 192 butterfly operations. A host loads 64 samples through a write port while the block is idle and pulses `start`. The block then runs six stages of 32 butterflies each and raises `done` for one cycle. After that, the 64 frequency bins can be read in natural order from a combinational read port.

Samples are stored at the bit-reversed form of their load index. This lets every stage work in place on butterfly pairs. One memory supplies the operands for a stage and a second memory collects the results. When a stage ends, the second memory is copied back over the first, so the next stage reads from the same locations. A control sequencer steps each butterfly through operand capture, complex multiply, add/subtract and write-back. Twiddle factors come from a table folded out of one quarter wave.

Top module: `fft64_seq`

## Requirements
- R1: After reset, `done` is low and the read port returns zero real and zero imaginary parts at every address.
- R2: Before a transform, the read port at address k shows the sample loaded at index rev(k), where rev reverses the six index bits (index 6 = 000110 appears at address 24 = 011000). Samples are sign-extended to the output width.
- R3: After `done`, read address k gives bin X[k] = sum over n of x[n]·e^(−j2πnk/64), in natural order and without scaling. Each part is within 40 + L1/32 LSB of the exact value, where L1 is the sum of |re| + |im| over all inputs. Twiddles are round(64·cos) − j·round(64·sin), and every product is rounded by adding 32 and shifting right 6 places.
- R4: An impulse at index 0 with value (a, b) gives exactly (a, b) in all 64 bins.
- R5: `done` is high for exactly one cycle. It first appears after the 774th rising edge that follows the edge that samples `start`, which is 6 × (32 × 4 + 1) cycles.
- R6: A `start` pulse while a transform is running has no effect: the latency and the results are unchanged.
- R7: `ld_valid` while a transform is running has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Write one input sample (honoured only while idle) |
| ld_idx | input | 6 | Time index of the sample being written |
| ld_re | input | 8 | Signed real part of the sample |
| ld_im | input | 8 | Signed imaginary part of the sample |
| start | input | 1 | Begin a transform (honoured only while idle) |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | input | 6 | Read address (bin index after a transform) |
| rd_re | output | DW (16) | Signed real part at `rd_idx` |
| rd_im | output | DW (16) | Signed imaginary part at `rd_idx` |

## Verification
The bench uses an impulse at index 0 because it must come through exactly. A wrong pair stride or a bad bit-reversal spreads that impulse across the bins as wrong values. Single tones at a low bin and at a high bin (61) catch a twiddle with the wrong sign or wrong folding, because the peak then lands in the mirrored bin. Stray `start` and `ld_valid` pulses in the middle of a run check the idle-only gating. A design that restarts the sequencer or writes the memory at that point gives a longer latency or corrupted bins. The exact 774-cycle latency and the one-cycle `done` catch an off-by-one in the butterfly or stage counters.

// File: rtl/fft64_pkg.sv
`timescale 1ns/1ps
package fft64_pkg;
    localparam int LOG2N   = 6;
    localparam int NPTS    = 1 << LOG2N;
    localparam int HALF    = NPTS / 2;
    localparam int TW_W    = 8;
    localparam int TW_FRAC = 6;

    typedef enum logic [2:0] {
        ST_RST, ST_BUF, ST_MUL, ST_ADD, ST_WR, ST_STG
    } seq_state_e;

    function automatic logic [LOG2N-1:0] bit_rev(input logic [LOG2N-1:0] a);
        logic [LOG2N-1:0] r;
        for (int i = 0; i < LOG2N; i++) r[i] = a[LOG2N-1-i];
        return r;
    endfunction

    // round(64 * cos(2*pi*k/64)) for the first quarter wave, k = 0..16
    function automatic logic signed [TW_W-1:0] quarter_cos(input int k);
        case (k)
            0, 1:    return 8'sd64;
            2:       return 8'sd63;
            3:       return 8'sd61;
            4:       return 8'sd59;
            5:       return 8'sd56;
            6:       return 8'sd53;
            7:       return 8'sd49;
            8:       return 8'sd45;
            9:       return 8'sd41;
            10:      return 8'sd36;
            11:      return 8'sd30;
            12:      return 8'sd24;
            13:      return 8'sd19;
            14:      return 8'sd12;
            15:      return 8'sd6;
            default: return 8'sd0;
        endcase
    endfunction
endpackage

// File: rtl/fft64_agu.sv
`timescale 1ns/1ps
module fft64_agu
    import fft64_pkg::*;
(
    input  logic [2:0]       stage,
    input  logic [LOG2N-2:0] bf,
    output logic [LOG2N-1:0] pair_p,
    output logic [LOG2N-1:0] pair_q,
    output logic [LOG2N-2:0] tw_idx
);
    logic [LOG2N-1:0] span;
    logic [LOG2N-2:0] mask;

    always_comb begin
        span   = (LOG2N)'(1) << stage;
        mask   = (LOG2N-1)'(span - 1'b1);
        pair_p = (({1'b0, bf} & ~{1'b0, mask}) << 1) | {1'b0, bf & mask};
        pair_q = pair_p | span;
        tw_idx = (LOG2N-1)'((bf & mask) << (LOG2N - 1 - int'(stage)));
    end
endmodule

// File: rtl/fft64_twiddle.sv
`timescale 1ns/1ps
module fft64_twiddle
    import fft64_pkg::*;
(
    input  logic [LOG2N-2:0]        idx,
    output logic signed [TW_W-1:0]  w_re,
    output logic signed [TW_W-1:0]  w_im
);
    localparam int QTR = NPTS / 4;

    always_comb begin
        if (int'(idx) <= QTR) begin
            w_re = quarter_cos(int'(idx));
            w_im = -quarter_cos(QTR - int'(idx));
        end else begin
            w_re = -quarter_cos(2*QTR - int'(idx));
            w_im = -quarter_cos(int'(idx) - QTR);
        end
    end
endmodule

// File: rtl/fft64_bfly.sv
`timescale 1ns/1ps
module fft64_bfly
    import fft64_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic                   mul_en,
    input  logic                   add_en,
    input  logic signed [DW-1:0]   a_re, a_im, b_re, b_im,
    input  logic signed [TW_W-1:0] w_re, w_im,
    output logic signed [DW-1:0]   o0_re, o0_im, o1_re, o1_im
);
    localparam int PW = DW + TW_W + 1;

    typedef struct packed {
        logic signed [DW-1:0]   a_re, a_im, b_re, b_im;
        logic signed [TW_W-1:0] w_re, w_im;
        logic signed [DW-1:0]   m_re, m_im;
        logic signed [DW-1:0]   o0_re, o0_im, o1_re, o1_im;
    } bfly_regs_t;

    bfly_regs_t bq_q, bq_d;
    logic signed [PW-1:0] pr, pi, half_lsb;

    always_comb begin
        bq_d     = bq_q;
        half_lsb = PW'(1 <<< (TW_FRAC - 1));
        pr = PW'(bq_q.b_re) * PW'(bq_q.w_re) - PW'(bq_q.b_im) * PW'(bq_q.w_im);
        pi = PW'(bq_q.b_re) * PW'(bq_q.w_im) + PW'(bq_q.b_im) * PW'(bq_q.w_re);
        if (cap_en) begin
            bq_d.a_re = a_re; bq_d.a_im = a_im;
            bq_d.b_re = b_re; bq_d.b_im = b_im;
            bq_d.w_re = w_re; bq_d.w_im = w_im;
        end
        if (mul_en) begin
            bq_d.m_re = DW'((pr + half_lsb) >>> TW_FRAC);
            bq_d.m_im = DW'((pi + half_lsb) >>> TW_FRAC);
        end
        if (add_en) begin
            bq_d.o0_re = bq_q.a_re + bq_q.m_re;
            bq_d.o0_im = bq_q.a_im + bq_q.m_im;
            bq_d.o1_re = bq_q.a_re - bq_q.m_re;
            bq_d.o1_im = bq_q.a_im - bq_q.m_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bq_q <= '0;
        else        bq_q <= bq_d;
    end

    assign o0_re = bq_q.o0_re;
    assign o0_im = bq_q.o0_im;
    assign o1_re = bq_q.o1_re;
    assign o1_im = bq_q.o1_im;

    // R3
    bfly_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |=> (DW'(o0_re + o1_re) == DW'(bq_q.a_re <<< 1)) &&
                   (DW'(o0_im + o1_im) == DW'(bq_q.a_im <<< 1)));
endmodule

// File: rtl/fft64_seq.sv
`timescale 1ns/1ps
module fft64_seq
    import fft64_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_valid,
    input  logic [LOG2N-1:0]     ld_idx,
    input  logic [IW-1:0]        ld_re,
    input  logic [IW-1:0]        ld_im,
    input  logic                 start,
    output logic                 done,
    input  logic [LOG2N-1:0]     rd_idx,
    output logic signed [DW-1:0] rd_re,
    output logic signed [DW-1:0] rd_im
);
    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } smp_t;

    typedef struct packed {
        seq_state_e       state;
        logic [2:0]       stage;
        logic [LOG2N-2:0] bf;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_q, ctrl_d;
    smp_t  ram_a [NPTS];
    smp_t  ram_b [NPTS];

    logic [LOG2N-1:0] pair_p, pair_q;
    logic [LOG2N-2:0] tw_idx;
    logic signed [TW_W-1:0] w_re, w_im;
    logic signed [DW-1:0] o0_re, o0_im, o1_re, o1_im;
    logic cap_en, mul_en, add_en, wr_en, copy_en, ld_ok;

    fft64_agu u_agu (
        .stage(ctrl_q.stage), .bf(ctrl_q.bf),
        .pair_p(pair_p), .pair_q(pair_q), .tw_idx(tw_idx)
    );

    fft64_twiddle u_tw (.idx(tw_idx), .w_re(w_re), .w_im(w_im));

    fft64_bfly #(.DW(DW)) u_bfly (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .mul_en(mul_en), .add_en(add_en),
        .a_re(ram_a[pair_p].re), .a_im(ram_a[pair_p].im),
        .b_re(ram_a[pair_q].re), .b_im(ram_a[pair_q].im),
        .w_re(w_re), .w_im(w_im),
        .o0_re(o0_re), .o0_im(o0_im), .o1_re(o1_re), .o1_im(o1_im)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        case (ctrl_q.state)
            ST_RST: if (start) begin
                ctrl_d.state = ST_BUF;
                ctrl_d.stage = '0;
                ctrl_d.bf    = '0;
            end
            ST_BUF: ctrl_d.state = ST_MUL;
            ST_MUL: ctrl_d.state = ST_ADD;
            ST_ADD: ctrl_d.state = ST_WR;
            ST_WR: begin
                if (ctrl_q.bf == (LOG2N-1)'(HALF-1)) ctrl_d.state = ST_STG;
                else begin
                    ctrl_d.bf    = ctrl_q.bf + 1'b1;
                    ctrl_d.state = ST_BUF;
                end
            end
            ST_STG: begin
                ctrl_d.bf = '0;
                if (ctrl_q.stage == 3'(LOG2N-1)) begin
                    ctrl_d.state = ST_RST;
                    ctrl_d.done  = 1'b1;
                end else begin
                    ctrl_d.stage = ctrl_q.stage + 1'b1;
                    ctrl_d.state = ST_BUF;
                end
            end
            default: ctrl_d.state = ST_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{state: ST_RST, stage: '0, bf: '0, done: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign cap_en  = (ctrl_q.state == ST_BUF);
    assign mul_en  = (ctrl_q.state == ST_MUL);
    assign add_en  = (ctrl_q.state == ST_ADD);
    assign wr_en   = (ctrl_q.state == ST_WR);
    assign copy_en = (ctrl_q.state == ST_STG);
    assign ld_ok   = ld_valid && (ctrl_q.state == ST_RST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTS; i++) begin
                ram_a[i] <= '0;
                ram_b[i] <= '0;
            end
        end else begin
            if (copy_en) begin
                for (int i = 0; i < NPTS; i++) ram_a[i] <= ram_b[i];
            end else if (ld_ok) begin
                ram_a[bit_rev(ld_idx)] <= '{re: {{(DW-IW){ld_re[IW-1]}}, ld_re},
                                           im: {{(DW-IW){ld_im[IW-1]}}, ld_im}};
            end
            if (wr_en) begin
                ram_b[pair_p] <= '{re: o0_re, im: o0_im};
                ram_b[pair_q] <= '{re: o1_re, im: o1_im};
            end
        end
    end

    assign done  = ctrl_q.done;
    assign rd_re = ram_a[rd_idx].re;
    assign rd_im = ram_a[rd_idx].im;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(ctrl_q.state) == ST_STG) && ($past(ctrl_q.stage) == 3'(LOG2N-1)));

    // R6
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state != ST_RST && ctrl_q.state != ST_STG) |=> $stable(ctrl_q.stage));

    // R3
    bf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_WR && ctrl_q.bf != (LOG2N-1)'(HALF-1)) |=>
            (ctrl_q.bf == $past(ctrl_q.bf) + 1'b1) && (ctrl_q.state == ST_BUF));

    // R3
    pair_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_BUF) |-> ((pair_q - pair_p) == ((LOG2N)'(1) << ctrl_q.stage)));
endmodule

// File: tb/tb_fft64_seq.sv
`timescale 1ns/1ps
module tb_fft64_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int LAT = 6 * (32 * 4 + 1) + 1;
    localparam real PI = 3.14159265358979;
    localparam int NPAT = 8;
    // {kind, amplitude, p, q}
    localparam logic [31:0] PATS [NPAT] = '{
        32'h00_64_00_25, 32'h00_5A_05_00, 32'h01_32_00_00, 32'h02_3C_03_00,
        32'h02_28_3D_00, 32'h03_46_00_00, 32'h04_00_5A_00, 32'h05_00_00_00
    };

    logic clk = 0, rst_n = 0, ld_valid = 0, start = 0, done;
    logic [5:0] ld_idx = 0, rd_idx = 0;
    logic [7:0] ld_re = 0, ld_im = 0;
    logic signed [DW-1:0] rd_re, rd_im;

    int n_chk = 0, n_fail = 0;
    int xr [64];
    int xi [64];

    fft64_seq dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_re(ld_re), .ld_im(ld_im), .start(start), .done(done),
        .rd_idx(rd_idx), .rd_re(rd_re), .rd_im(rd_im)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int rev6(input int a);
        int r = 0;
        for (int i = 0; i < 6; i++) if (a[i]) r |= 1 << (5 - i);
        return r;
    endfunction

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input string req, input bit ok, input int k,
                         input int gr, input int gi, input int er, input int ei);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s k=%0d actual (%0d,%0d) expected (%0d,%0d)", req, k, gr, gi, er, ei);
        end
    endtask

    task automatic gen(input logic [31:0] pat);
        int kind = int'(pat[31:24]);
        int amp = int'(pat[23:16]);
        int p = int'(pat[15:8]);
        int q = int'(pat[7:0]);
        logic [15:0] lf = {8'hA5, pat[15:8]};
        for (int n = 0; n < 64; n++) begin
            real th = 2.0 * PI * p * n / 64.0;
            case (kind)
                0: begin xr[n] = (n == p) ? amp : 0; xi[n] = (n == p) ? -q : 0; end
                1: begin xr[n] = amp; xi[n] = amp / 2; end
                2: begin xr[n] = rnd(amp * $cos(th)); xi[n] = rnd(amp * $sin(th)); end
                3: begin xr[n] = n[0] ? -amp : amp; xi[n] = 0; end
                4: begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    xr[n] = int'($signed(lf[7:0]));
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    xi[n] = int'($signed(lf[7:0]));
                end
                default: begin xr[n] = 3 * n - 96; xi[n] = 40 - n; end
            endcase
        end
    endtask

    task automatic load_all();
        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            ld_valid = 1; ld_idx = 6'(n); ld_re = 8'(xr[n]); ld_im = 8'(xi[n]);
        end
        @(negedge clk); ld_valid = 0;
    endtask

    // stray_start / stray_load: cycle count at which to inject, -1 for none
    task automatic run(input string req, input int stray_start, input int stray_load);
        int lat;
        @(negedge clk); start = 1;
        @(posedge clk); lat = 1;
        @(negedge clk); start = 0;
        while (!done && lat < 3000) begin
            start = (lat == stray_start);
            ld_valid = (lat == stray_load);
            ld_idx = 6'd0; ld_re = 8'h7f; ld_im = 8'h80;
            @(posedge clk); lat++;
            @(negedge clk);
        end
        start = 0; ld_valid = 0;
        check({req, " latency"}, lat == LAT, -1, lat, 0, LAT, 0);
        @(negedge clk);
        check("R5 done one cycle", done == 1'b0, -1, int'(done), 0, 0, 0);
    endtask

    task automatic read_bin(input int k, output int gr, output int gi);
        @(negedge clk); rd_idx = 6'(k); #1;
        gr = int'(rd_re); gi = int'(rd_im);
    endtask

    task automatic check_bins(input string req, input bit exact);
        int l1 = 0, tol, gr, gi, er, ei;
        for (int n = 0; n < 64; n++) l1 += (xr[n] < 0 ? -xr[n] : xr[n]) + (xi[n] < 0 ? -xi[n] : xi[n]);
        tol = exact ? 0 : 40 + l1 / 32;
        for (int k = 0; k < 64; k++) begin
            real sr = 0.0, si = 0.0;
            for (int n = 0; n < 64; n++) begin
                real th = 2.0 * PI * n * k / 64.0;
                sr += xr[n] * $cos(th) + xi[n] * $sin(th);
                si += xi[n] * $cos(th) - xr[n] * $sin(th);
            end
            er = rnd(sr); ei = rnd(si);
            read_bin(k, gr, gi);
            check(req, (gr - er <= tol) && (er - gr <= tol) && (gi - ei <= tol) && (ei - gi <= tol),
                  k, gr, gi, er, ei);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int gr, gi;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        @(negedge clk);
        check("R1 done low", done == 1'b0, -1, int'(done), 0, 0, 0);
        for (int k = 0; k < 64; k += 7) begin
            read_bin(k, gr, gi);
            check("R1 zero memory", gr == 0 && gi == 0, k, gr, gi, 0, 0);
        end
        // R2: bit-reversed placement and sign extension
        gen(PATS[7]);
        load_all();
        for (int k = 0; k < 64; k++) begin
            read_bin(k, gr, gi);
            check("R2 bit-reversed load", gr == xr[rev6(k)] && gi == xi[rev6(k)],
                  k, gr, gi, xr[rev6(k)], xi[rev6(k)]);
        end
        // R3 / R4 / R5: table of input patterns
        for (int t = 0; t < NPAT; t++) begin
            gen(PATS[t]);
            load_all();
            run("R5", -1, -1);
            if (PATS[t][31:24] == 8'h00 && PATS[t][15:8] == 8'h00) check_bins("R4 impulse exact", 1'b1);
            else check_bins("R3 transform", 1'b0);
        end
        // R6: stray start pulses during a run
        gen(PATS[3]);
        load_all();
        run("R6", 300, -1);
        check_bins("R6 start ignored", 1'b0);
        // R7: stray load during a run
        gen(PATS[4]);
        load_all();
        run("R7", -1, 400);
        check_bins("R7 load ignored", 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule